// File: doc/BRIEF.md
# Outbound Configuration Cycle Initiator

This block lets a local processor launch single configuration reads and writes on a downstream PCI or PCI-X segment using two internal-bus registers. Software first loads the target configuration address into an address register. Each access to the second location, a data window, then starts exactly one downstream configuration transaction that uses the stored address. The window holds no data. A write to it forwards the written word downstream and completes at once. A read of it releases the requester straight away, and the data arrives later as a split completion.

Software always writes a Type 0 address in the PCI-X layout. When the segment runs in conventional mode, the block rewrites that address by clearing bits 15:11. For Type 0 cycles it also fills the attribute-phase secondary bus field from the requester bus number. The downstream side is an abstract request/grant/response handshake. Only one transaction may be in flight at a time.

Top module: `cfg_cycle_init`

## Requirements
- R1: After reset, dn_req, lb_cpl_valid and cfg_err are 0, and the address register reads back as 0.
- R2: A write to the address register (offset 0x0) updates only the bytes whose lb_be bit is set. A read of that register returns the stored value on lb_rdata, with lb_ack high in the same cycle.
- R3: A write to the data window (offset 0x4) while idle is acknowledged in the same cycle. From the next cycle, dn_req is 1 with dn_write=1, the written data and the written 4-bit lane mask. The request and its address stay unchanged until a cycle with dn_gnt=1.
- R4: A read of the data window while idle is acknowledged in the same cycle without data. The downstream request has dn_write=0 and lane mask 4'hF. One cycle after dn_rsp_valid, lb_cpl_valid pulses with the response data. Writes never produce a completion.
- R5: A data-window read for which address bits 1:0 plus lb_len (the byte count) exceeds 4 raises lb_abort in the same cycle, gets no lb_ack, and starts no downstream request.
- R6: Address bits 1:0 equal to 00 mark a Type 0 cycle. For such a cycle, dn_addr has bits 15:11 cleared when pcix_mode=0 at launch, and equals the stored address when pcix_mode=1. Other type codes pass through unchanged in both modes.
- R7: For a Type 0 cycle, dn_sec_bus equals req_bus_num at launch. For any other type it is 0.
- R8: While a transaction is pending (from launch until the cycle after its response), a further data-window access gets no lb_ack.
- R9: A read response with dn_rsp_mabort=1 completes with data 32'hFFFF_FFFF and sets cfg_err, which then stays set until reset. A master abort on a write leaves cfg_err unchanged.
- R10: Every data-window read yields a fresh downstream read, and each returns its own response data; no earlier value is replayed.
- R11: dn_type1 is 1 exactly when stored address bits 1:0 are not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_wr | input | 1 | Internal-bus write request |
| lb_rd | input | 1 | Internal-bus read request |
| lb_addr | input | ADDR_W | Byte offset of the access |
| lb_be | input | 4 | Write byte enables |
| lb_len | input | 4 | Read length in bytes |
| lb_wdata | input | 32 | Write data |
| lb_ack | output | 1 | Access accepted this cycle |
| lb_abort | output | 1 | Target abort of a crossing window read |
| lb_rdata | output | 32 | Address register read data |
| lb_cpl_valid | output | 1 | Split completion strobe |
| lb_cpl_data | output | 32 | Split completion data |
| pcix_mode | input | 1 | 1 = PCI-X segment, 0 = conventional |
| req_bus_num | input | 8 | Requester bus number (status bits 15:8) |
| dn_req | output | 1 | Downstream request valid |
| dn_write | output | 1 | 1 = configuration write |
| dn_type1 | output | 1 | 1 = Type 1 cycle |
| dn_addr | output | 32 | Translated configuration address |
| dn_be | output | 4 | Lane mask of the single data phase |
| dn_wdata | output | 32 | Write data |
| dn_sec_bus | output | 8 | Attribute secondary bus number |
| dn_gnt | input | 1 | Downstream accepts the request |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_data | input | 32 | Response read data |
| dn_rsp_mabort | input | 1 | Response reports master abort |
| cfg_err | output | 1 | Sticky read master-abort flag |

## Verification
The main stimulus sweeps all 32 device-number values through address bits 15:11, for both Type 0 and Type 1 codes and in both bus modes, alternating reads and writes. This separates clearing from pass-through and shows that the mode is sampled only for Type 0. Grant and response delays vary, which shows that requests hold steady while waiting and that stalled window accesses are refused. Every combination of offset and byte count for window reads is tried, which separates aborting crossings from accepted reads. Master aborts on a write and then on a read show that only the read sets the sticky flag and returns all-ones data.

// File: rtl/cfg_cycle_init.sv
module cfg_cycle_init #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_OFS = 'h0,
  parameter logic [ADDR_W-1:0] WIN_OFS  = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_wr,
  input  logic              lb_rd,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [3:0]        lb_be,
  input  logic [3:0]        lb_len,
  input  logic [31:0]       lb_wdata,
  output logic              lb_ack,
  output logic              lb_abort,
  output logic [31:0]       lb_rdata,
  output logic              lb_cpl_valid,
  output logic [31:0]       lb_cpl_data,
  input  logic              pcix_mode,
  input  logic [7:0]        req_bus_num,
  output logic              dn_req,
  output logic              dn_write,
  output logic              dn_type1,
  output logic [31:0]       dn_addr,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  output logic [7:0]        dn_sec_bus,
  input  logic              dn_gnt,
  input  logic              dn_rsp_valid,
  input  logic [31:0]       dn_rsp_data,
  input  logic              dn_rsp_mabort,
  output logic              cfg_err
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t         st;
  logic [31:0] addr_q;
  logic [31:0] addr_nx;
  logic [31:0] tx_addr;
  logic [4:0]  span;
  logic        hit_adr, hit_win, is_t0, rd_cross, win_go;

  assign hit_adr  = lb_addr[ADDR_W-1:2] == ADDR_OFS[ADDR_W-1:2];
  assign hit_win  = lb_addr[ADDR_W-1:2] == WIN_OFS[ADDR_W-1:2];
  assign span     = {3'b000, lb_addr[1:0]} + {1'b0, lb_len};
  assign rd_cross = lb_rd && hit_win && (span > 5'd4);
  assign win_go   = (lb_wr || lb_rd) && hit_win && !rd_cross && (st == S_IDLE);

  assign lb_abort = rd_cross;
  assign lb_ack   = ((lb_wr || lb_rd) && !hit_win) || win_go;
  assign lb_rdata = (lb_rd && hit_adr) ? addr_q : 32'h0;

  assign is_t0   = addr_q[1:0] == 2'b00;
  assign tx_addr = (is_t0 && !pcix_mode) ? {addr_q[31:16], 5'b00000, addr_q[10:0]} : addr_q;
  assign dn_req  = st == S_REQ;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign addr_nx[8*i +: 8] = lb_be[i] ? lb_wdata[8*i +: 8] : addr_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= 32'h0;
    end else if (lb_wr && hit_adr) begin
      addr_q <= addr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      dn_write     <= 1'b0;
      dn_type1     <= 1'b0;
      dn_addr      <= 32'h0;
      dn_be        <= 4'h0;
      dn_wdata     <= 32'h0;
      dn_sec_bus   <= 8'h0;
      lb_cpl_valid <= 1'b0;
      lb_cpl_data  <= 32'h0;
      cfg_err      <= 1'b0;
    end else begin
      lb_cpl_valid <= 1'b0;
      case (st)
        S_IDLE: if (win_go) begin
          st         <= S_REQ;
          dn_write   <= lb_wr;
          dn_type1   <= !is_t0;
          dn_addr    <= tx_addr;
          dn_be      <= lb_wr ? lb_be : 4'hF;
          dn_wdata   <= lb_wr ? lb_wdata : 32'h0;
          dn_sec_bus <= is_t0 ? req_bus_num : 8'h0;
        end
        S_REQ: if (dn_gnt) st <= S_WAIT;
        S_WAIT: if (dn_rsp_valid) begin
          st <= S_IDLE;
          if (!dn_write) begin
            lb_cpl_valid <= 1'b1;
            lb_cpl_data  <= dn_rsp_mabort ? 32'hFFFF_FFFF : dn_rsp_data;
            if (dn_rsp_mabort) cfg_err <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_gnt |=> dn_req && $stable(dn_addr) && $stable(dn_wdata)); // R3
  AST_RD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_write |-> dn_be == 4'hF); // R4
  AST_CPL_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    lb_cpl_valid |-> $past(dn_rsp_valid) && !$past(dn_req)); // R4
  AST_ABORT_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    lb_abort && !dn_req |=> !dn_req); // R5
  AST_CONV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) && !dn_type1 && !$past(pcix_mode) |-> dn_addr[15:11] == 5'h0); // R6
  AST_LAUNCH_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(lb_ack)); // R8
  AST_NO_CPL_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !lb_cpl_valid); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R9

endmodule

// File: tb/sim_cfg_cycle_init.sv
`timescale 1ns/1ps
module sim_cfg_cycle_init;
  logic        clk = 0, rst_n = 0;
  logic        lb_wr = 0, lb_rd = 0;
  logic [3:0]  lb_addr = 0, lb_be = 0, lb_len = 0;
  logic [31:0] lb_wdata = 0;
  logic        lb_ack, lb_abort, lb_cpl_valid;
  logic [31:0] lb_rdata, lb_cpl_data;
  logic        pcix_mode = 0;
  logic [7:0]  req_bus_num = 0;
  logic        dn_req, dn_write, dn_type1;
  logic [31:0] dn_addr, dn_wdata;
  logic [3:0]  dn_be;
  logic [7:0]  dn_sec_bus;
  logic        dn_gnt = 0, dn_rsp_valid = 0, dn_rsp_mabort = 0;
  logic [31:0] dn_rsp_data = 0;
  logic        cfg_err;

  int checks = 0, errors = 0;
  bit exp_err = 0;

  always #4 clk = ~clk;

  cfg_cycle_init u0 (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(logic [31:0] d, logic [3:0] be);
    @(negedge clk); lb_wr = 1; lb_addr = 4'h0; lb_be = be; lb_wdata = d; #2;
    chk(lb_ack == 1, "R2 ack", {31'h0, lb_ack}, 1);
    @(negedge clk); lb_wr = 0;
  endtask

  task automatic reg_rd(logic [31:0] exp, string req);
    @(negedge clk); lb_rd = 1; lb_addr = 4'h0; lb_len = 4; #2;
    chk(lb_ack == 1 && lb_rdata == exp, req, lb_rdata, exp);
    @(negedge clk); lb_rd = 0;
  endtask

  task automatic win_op(bit wr, logic [1:0] ofs, logic [3:0] len, logic [3:0] be,
                        logic [31:0] wd, int gd, logic [31:0] rd, bit ma, bit stall,
                        logic [31:0] ea, bit et1, logic [7:0] es);
    @(negedge clk);
    lb_wr = wr; lb_rd = !wr; lb_addr = {2'b01, ofs}; lb_be = be; lb_len = len; lb_wdata = wd; #2;
    chk(lb_ack == 1 && lb_abort == 0, wr ? "R3 ack" : "R4 ack", {lb_abort, lb_ack}, 1);
    @(negedge clk); lb_wr = 0; lb_rd = 0;
    chk(dn_req == 1 && dn_write == wr, "R3/R4 request", {dn_req, dn_write}, {1'b1, wr});
    chk(dn_addr == ea, "R6 address", dn_addr, ea);
    chk(dn_type1 == et1, "R11 type", dn_type1, et1);
    chk(dn_sec_bus == es, "R7 secondary bus", dn_sec_bus, es);
    if (wr) begin
      chk(dn_be == be, "R3 lanes", dn_be, be);
      chk(dn_wdata == wd, "R3 data", dn_wdata, wd);
    end else chk(dn_be == 4'hF, "R4 lanes", dn_be, 4'hF);
    for (int k = 0; k < gd; k++) begin
      @(negedge clk);
      chk(dn_req == 1 && dn_addr == ea, "R3 hold", dn_addr, ea);
    end
    dn_gnt = 1;
    @(negedge clk); dn_gnt = 0;
    chk(dn_req == 0, "R3 released", dn_req, 0);
    if (stall) begin
      lb_rd = 1; lb_addr = 4'h4; lb_len = 4; #2;
      chk(lb_ack == 0, "R8 stall", lb_ack, 0);
      lb_rd = 0;
    end
    @(negedge clk); dn_rsp_valid = 1; dn_rsp_data = rd; dn_rsp_mabort = ma;
    @(negedge clk); dn_rsp_valid = 0; dn_rsp_mabort = 0;
    chk(lb_cpl_valid == !wr, "R4 completion strobe", lb_cpl_valid, !wr);
    if (!wr) begin
      if (ma) exp_err = 1;
      chk(lb_cpl_data == (ma ? 32'hFFFF_FFFF : rd), ma ? "R9 abort data" : "R4 R10 data",
          lb_cpl_data, ma ? 32'hFFFF_FFFF : rd);
    end
    chk(cfg_err == exp_err, "R9 flag", cfg_err, exp_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dn_req == 0 && lb_cpl_valid == 0 && cfg_err == 0, "R1 reset outputs",
        {dn_req, lb_cpl_valid, cfg_err}, 0);
    reg_rd(32'h0, "R1 address reset");

    reg_wr(32'hA5A5_5A5A, 4'hF);
    reg_rd(32'hA5A5_5A5A, "R2 full write");
    reg_wr(32'h1122_3C44, 4'b0010);
    reg_rd(32'hA5A5_3C5A, "R2 lane merge");
    reg_wr(32'h7700_0000, 4'b1000);
    reg_rd(32'h77A5_3C5A, "R2 top lane");

    for (int m = 0; m < 2; m++) begin
      for (int ty = 0; ty < 3; ty++) begin
        for (int dev = 0; dev < 32; dev++) begin
          logic [31:0] a, ea;
          logic [7:0] bus;
          bit wr, ma;
          a   = 32'h00AB_0000 | (dev << 11) | (3 << 8) | 32'h40 | ty;
          ea  = (ty == 0 && m == 0) ? (a & ~32'h0000_F800) : a;
          bus = 8'((dev * 7 + m * 3) & 255);
          wr  = dev[0];
          ma  = (m == 0 && ty == 0 && dev == 1) || (m == 1 && ty == 1 && dev == 30);
          reg_wr(a, 4'hF);
          pcix_mode = m[0]; req_bus_num = bus;
          win_op(wr, 2'b00, 4'd4, 4'hF - 4'(dev % 3), 32'hD000_0000 + dev * 3 + m,
                 dev % 3, 32'hC0DE_0000 + dev * 16 + ty * 4 + m, ma, (dev % 4) == 2,
                 ea, ty != 0, ty == 0 ? bus : 8'h0);
        end
      end
    end

    pcix_mode = 0; req_bus_num = 8'h3C;
    reg_wr(32'h0000_F8A0, 4'hF);
    for (int ofs = 0; ofs < 4; ofs++) begin
      for (int len = 1; len <= 8; len++) begin
        if (ofs + len > 4) begin
          @(negedge clk); lb_rd = 1; lb_addr = 4'h4 | 4'(ofs); lb_len = 4'(len); #2;
          chk(lb_abort == 1 && lb_ack == 0, "R5 abort", {lb_abort, lb_ack}, 2'b10);
          @(negedge clk); lb_rd = 0;
          chk(dn_req == 0, "R5 no request", dn_req, 0);
          @(negedge clk);
          chk(dn_req == 0, "R5 still idle", dn_req, 0);
        end else begin
          win_op(0, 2'(ofs), 4'(len), 4'hF, 0, 1, 32'h5000_0000 + ofs * 8 + len, 0, 0,
                 32'h0000_00A0, 0, 8'h3C);
        end
      end
    end

    win_op(0, 0, 4, 4'hF, 0, 0, 32'h1111_1111, 0, 0, 32'h0000_00A0, 0, 8'h3C);
    win_op(0, 0, 4, 4'hF, 0, 0, 32'h2222_2222, 0, 0, 32'h0000_00A0, 0, 8'h3C); // R10

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule